// File: doc/BRIEF.md
# SCL Half-Period Rate Generator

This block paces the SCL line of an I2C bus master. A 7-bit rate field, taken from the low bits of an 8-bit configuration byte, sets how many core-clock cycles each half of the SCL period lasts. Each time a half-period runs out, the block pulses a one-cycle tick. It also issues a direction-qualified request to raise or lower the internal SCL level, and it keeps that level on a registered output that the pad logic uses to release or drive the line. The resulting SCL frequency is the core clock divided by twice the rate field. For example, a field of 5 with a 4 MHz core clock gives 400 kHz.

The counter counts down and stops at zero instead of wrapping. After a low phase ends and the line is released, the counter stays parked at zero while the observed SCL level is still low, for example when a slave stretches the clock. The high phase only starts counting in the first cycle in which SCL is seen high, so a stretched clock never shortens the high time. While master mode is off, no ticks come out, the internal level stays released, and the counter is held at the reload value. The first half-period after enabling therefore always has its full length.

Top module: `scl_rategen`

## Requirements
- R1: Bit 7 of `cfg_rate` has no effect; a byte with bit 7 set gives exactly the same tick timing as the same byte with bit 7 clear.
- R2: With master mode active and no stretching, ticks are spaced exactly R core-clock cycles apart, where R is `cfg_rate[6:0]`, so a full SCL period is 2R cycles.
- R3: A rate field of 0 behaves as R = 1, which gives a tick in every active cycle.
- R4: `half_tick` is a single-cycle pulse; for R of at least 2 it is never high in two consecutive cycles.
- R5: While `master_en` is low, `half_tick`, `scl_rise` and `scl_fall` stay low and `scl_release` is 1. The counter is held at the reload value, so the first tick after `master_en` rises comes R cycles later, counting the enabling cycle.
- R6: Each tick toggles `scl_release` on the next clock. In the tick cycle, `scl_fall` is 1 if `scl_release` is 1 (the line is about to be driven low), and `scl_rise` is 1 if `scl_release` is 0 (the line is about to be released). Outside tick cycles both are 0.
- R7: After a rising request, every cycle in which `scl_in` is seen low is a stall: no tick occurs and the counter stays at zero. The high phase begins in the first cycle in which `scl_in` is seen high, and the next tick comes R cycles later, counting that cycle.
- R8: During and right after reset, `scl_release` is 1 and `half_tick` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Master mode active |
| cfg_rate | input | 8 | Configuration byte; bits 6:0 hold the half-period in cycles, bit 7 is ignored |
| scl_in | input | 1 | Observed SCL pin level |
| half_tick | output | 1 | One-cycle pulse at the end of each half-period |
| scl_rise | output | 1 | Tick that requests a release of SCL (low to high) |
| scl_fall | output | 1 | Tick that requests SCL be driven low (high to low) |
| scl_release | output | 1 | Internal SCL level: 1 releases the line, 0 drives it low |

## Verification
Two functions can fall in the same cycle: the end of a stretch, where the deferred reload fires because SCL is finally seen high, and the terminal count. With a rate field of 1, the cycle in which the slave lets go is both the reload cycle and the zero cycle, so it must produce the falling tick at once. The bench provokes this by holding `scl_in` low for several cycles after a rising request at R = 1, and it does the same at R = 3. A scoreboard predicts the exact cycle and direction of every tick from R and from the release cycle of the stretch, and judges the result by the tick cycle, the direction strobes and the level of `scl_release` in that cycle.

// File: rtl/scl_rategen_pkg.sv
package scl_rategen_pkg;

  // phase of the SCL waveform generator
  typedef enum logic [1:0] {
    PH_IDLE      = 2'd0,
    PH_COUNT     = 2'd1,
    PH_WAIT_HIGH = 2'd2
  } phase_e;

  // control handed from the phase tracker to the down counter
  typedef struct packed {
    logic clear;       // master mode off: hold at reload value
    logic use_load;    // counting starts from the reload value this cycle
    logic freeze;      // stretch stall: keep the count
    logic arm_reload;  // a terminal count reloads (next phase is low)
  } cnt_ctl_t;

endpackage

// File: rtl/scl_rategen_sync.sv
module scl_rategen_sync #(
  parameter int STAGES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (STAGES == 0) begin : g_pass
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q = d;
    end else begin : g_flops
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '1;
        end else begin
          chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d};
        end
      end
      assign q = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/scl_rategen_reload.sv
module scl_rategen_reload #(
  parameter int CFG_W = 8,
  parameter int RLD_W = 7
) (
  input  logic [CFG_W-1:0] cfg_raw,
  output logic [RLD_W-1:0] load_m1
);

  // half-period in cycles, a zero field counts as one
  function automatic logic [RLD_W-1:0] f_half_cycles(input logic [RLD_W-1:0] field);
    return (field == '0) ? RLD_W'(1) : field;
  endfunction

  // the cycle that loads the counter is itself the first cycle of the phase
  function automatic logic [RLD_W-1:0] f_load_value(input logic [RLD_W-1:0] field);
    return f_half_cycles(field) - RLD_W'(1);
  endfunction

  assign load_m1 = f_load_value(cfg_raw[RLD_W-1:0]);

  generate
    if (CFG_W > RLD_W) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^cfg_raw[CFG_W-1:RLD_W];
    end
  endgenerate

endmodule

// File: rtl/scl_rategen_counter.sv
module scl_rategen_counter
  import scl_rategen_pkg::*;
#(
  parameter int RLD_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_ctl_t         ctl,
  input  logic [RLD_W-1:0] load_m1,
  output logic [RLD_W-1:0] cnt_q,
  output logic             terminal
);

  logic [RLD_W-1:0] cur_val;

  assign cur_val  = ctl.use_load ? load_m1 : cnt_q;
  assign terminal = (cur_val == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ctl.clear) begin
      cnt_q <= load_m1;
    end else if (ctl.freeze) begin
      cnt_q <= cnt_q;
    end else if (terminal) begin
      // halt at zero unless the coming phase reloads at once
      cnt_q <= ctl.arm_reload ? load_m1 : '0;
    end else begin
      cnt_q <= cur_val - RLD_W'(1);
    end
  end

endmodule

// File: rtl/scl_rategen_phase.sv
module scl_rategen_phase
  import scl_rategen_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     terminal,
  input  logic     scl_seen,
  output cnt_ctl_t ctl,
  output logic     tick,
  output logic     rise_req,
  output logic     fall_req,
  output logic     level_q,
  output logic     stall
);

  phase_e state_q;

  assign stall    = en && (state_q == PH_WAIT_HIGH) && !scl_seen;
  assign tick     = en && terminal && !stall;
  assign rise_req = tick && !level_q;
  assign fall_req = tick && level_q;

  always_comb begin
    ctl.clear      = !en;
    ctl.use_load   = (state_q != PH_COUNT);
    ctl.freeze     = stall;
    ctl.arm_reload = level_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      level_q <= 1'b1;
    end else if (!en) begin
      state_q <= PH_IDLE;
      level_q <= 1'b1;
    end else if (tick) begin
      level_q <= !level_q;
      state_q <= level_q ? PH_COUNT : PH_WAIT_HIGH;
    end else if (state_q == PH_WAIT_HIGH) begin
      state_q <= scl_seen ? PH_COUNT : PH_WAIT_HIGH;
    end else begin
      state_q <= PH_COUNT;
    end
  end

endmodule

// File: rtl/scl_rategen.sv
module scl_rategen
  import scl_rategen_pkg::*;
#(
  parameter int CFG_W       = 8,
  parameter int RLD_W       = 7,
  parameter int SYNC_STAGES = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic [CFG_W-1:0] cfg_rate,
  input  logic             scl_in,
  output logic             half_tick,
  output logic             scl_rise,
  output logic             scl_fall,
  output logic             scl_release
);

  logic             scl_seen;
  logic [RLD_W-1:0] load_m1;
  logic [RLD_W-1:0] cnt_w;
  logic             terminal_w;
  logic             stall_w;
  cnt_ctl_t         ctl_w;

  scl_rategen_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (scl_in),
    .q     (scl_seen)
  );

  scl_rategen_reload #(.CFG_W(CFG_W), .RLD_W(RLD_W)) u_reload (
    .cfg_raw (cfg_rate),
    .load_m1 (load_m1)
  );

  scl_rategen_counter #(.RLD_W(RLD_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl_w),
    .load_m1  (load_m1),
    .cnt_q    (cnt_w),
    .terminal (terminal_w)
  );

  scl_rategen_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (master_en),
    .terminal (terminal_w),
    .scl_seen (scl_seen),
    .ctl      (ctl_w),
    .tick     (half_tick),
    .rise_req (scl_rise),
    .fall_req (scl_fall),
    .level_q  (scl_release),
    .stall    (stall_w)
  );

endmodule

// File: rtl/scl_rategen_checker.sv
module scl_rategen_checker #(
  parameter int RLD_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             master_en,
  input logic             half_tick,
  input logic             scl_rise,
  input logic             scl_fall,
  input logic             scl_release,
  input logic             stall,
  input logic [RLD_W-1:0] cnt_q,
  input logic [RLD_W-1:0] load_m1
);

  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> !half_tick); // R5

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> scl_release); // R5

  AST_TICK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |=> (scl_release != $past(scl_release))); // R6

  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && !half_tick) |=> $stable(scl_release)); // R6

  AST_RISE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |=> scl_release); // R6

  AST_FALL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |=> !scl_release); // R6

  AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall})); // R6

  AST_STRETCH_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !half_tick); // R7

  AST_STRETCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && master_en) |=> $stable(cnt_q)); // R7

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && scl_release && load_m1 != '0) |=> !half_tick); // R4

endmodule

bind scl_rategen scl_rategen_checker #(.RLD_W(RLD_W)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .master_en   (master_en),
  .half_tick   (half_tick),
  .scl_rise    (scl_rise),
  .scl_fall    (scl_fall),
  .scl_release (scl_release),
  .stall       (stall_w),
  .cnt_q       (cnt_w),
  .load_m1     (load_m1)
);

// File: tb/scl_rategen_test.sv
module scl_rategen_test;

  typedef struct {
    int    cyc;
    bit    rise;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master_en = 1'b0;
  logic [7:0] cfg_rate = 8'h00;
  logic       slave_hold = 1'b0;
  logic       scl_in;
  logic       half_tick, scl_rise, scl_fall, scl_release;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t expq[$];

  // open-drain wire: low if the master drives low or a slave holds it
  assign scl_in = scl_release && !slave_hold;

  always #10ns clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  scl_rategen uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_en   (master_en),
    .cfg_rate    (cfg_rate),
    .scl_in      (scl_in),
    .half_tick   (half_tick),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .scl_release (scl_release)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  // driver: predicts every tick of one enabled run, then plays the run
  task automatic run_case(input logic [7:0] cfg, input int len,
                          input int stretch_k, input int stretch_len,
                          input string req);
    int   r;
    int   e0;
    int   t;
    int   k;
    int   nrise;
    int   s_at;
    bit   after_stretch;
    exp_t item;
    @(negedge clk);
    master_en  = 1'b0;
    slave_hold = 1'b0;
    cfg_rate   = cfg;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #5ns;
      check(half_tick === 1'b0 && scl_release === 1'b1 && scl_rise === 1'b0 && scl_fall === 1'b0,
            "R5", "idle outputs {tick,release}", {half_tick, scl_release}, 1);
    end
    @(negedge clk);
    e0 = cyc;
    r = (cfg[6:0] == 7'd0) ? 1 : int'(cfg[6:0]);
    t = e0 + r - 1;
    k = 1;
    nrise = 0;
    s_at = -1;
    after_stretch = 1'b0;
    while (t <= e0 + len - 1) begin
      item.cyc  = t;
      item.rise = (k % 2 == 0);
      item.req  = after_stretch ? "R7" : req;
      expq.push_back(item);
      after_stretch = 1'b0;
      if (item.rise) begin
        nrise++;
        if (nrise == stretch_k) begin
          s_at = t;
          after_stretch = 1'b1;
          t = t + stretch_len + r;
        end else begin
          t = t + r;
        end
      end else begin
        t = t + r;
      end
      k++;
    end
    master_en = 1'b1;
    for (int i = 0; i < len; i++) begin
      slave_hold = (s_at >= 0) && (cyc >= s_at) && (cyc < s_at + 1 + stretch_len);
      @(negedge clk);
    end
    master_en  = 1'b0;
    slave_hold = 1'b0;
    @(negedge clk);
    #5ns;
    check(expq.size() == 0, req, "predicted ticks not seen", expq.size(), 0);
  endtask

  // monitor: compares every observed tick with the head of the scoreboard
  initial begin
    exp_t e;
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      #5ns;
      if (half_tick === 1'b1) begin
        if (expq.size() == 0) begin
          check(1'b0, "R4", "unexpected half_tick at cycle", cyc, -1);
        end else begin
          e = expq.pop_front();
          check(cyc == e.cyc, e.req, "tick cycle", cyc, e.cyc);
          check(scl_rise == e.rise && scl_fall == !e.rise, "R6",
                "direction {rise,fall}", {scl_rise, scl_fall}, {e.rise, !e.rise});
          check(scl_release == !e.rise, "R6", "level in tick cycle",
                scl_release, !e.rise);
        end
      end else if (scl_rise === 1'b1 || scl_fall === 1'b1) begin
        check(1'b0, "R6", "direction strobe without tick", {scl_rise, scl_fall}, 0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #5ns;
    check(half_tick === 1'b0 && scl_release === 1'b1, "R8", "outputs in reset",
          {half_tick, scl_release}, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5ns;
    check(half_tick === 1'b0 && scl_release === 1'b1, "R8", "outputs after reset",
          {half_tick, scl_release}, 1);

    run_case(8'h05, 40, 0, 0, "R2");
    run_case(8'h85, 40, 0, 0, "R1");
    run_case(8'h00, 12, 0, 0, "R3");
    run_case(8'h80,  9, 0, 0, "R3");
    run_case(8'h02, 14, 0, 0, "R4");
    run_case(8'h03, 40, 2, 7, "R7");
    run_case(8'h01, 20, 1, 4, "R7");
    run_case(8'h06, 30, 0, 0, "R5");
    run_case(8'h7F, 600, 1, 10, "R2");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule